// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic read and write an external asynchronous static RAM of 131,072 bytes. A request port with a valid/ready handshake takes one command at a time: a read/write flag, a 17-bit word address and a byte of write data. Reads return a byte together with a one-clock valid strobe. Writes return nothing.

On the memory side the block drives three active-low strobes: chip select, write strobe and output enable. It also drives the address bus and a data bus split into an outbound byte, a drive-enable and an inbound byte. Together these stand in for a bidirectional pad.

The block produces every memory timing from system clocks. The access time and the write-pulse width are given as picosecond parameters, and each is turned into a whole number of clocks by rounding up. Every strobe and bus-enable comes straight from a flop, so the memory never sees a combinational glitch.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever the controller is idle, chip select, write strobe and output enable are high, the bus drive-enable is low, ready is high and the read-valid strobe is low.
- R2: A command is taken on a clock edge where valid and ready are both high. Ready is high only while idle and stays low for the whole access. A write keeps ready low for WP+2 clocks and a read for ACC+1 clocks after the accepting edge.
- R3: During a write, chip select is low and output enable is high throughout. The write strobe falls one clock after acceptance and stays low for exactly WP clocks. The write strobe is never low while chip select is high.
- R4: Address and write data are driven one clock before the write strobe falls and do not change while it is low. After the write strobe rises, the bus stays driven with chip select low for one more clock. The memory takes the byte on that rising edge.
- R5: During a read, chip select and output enable are low, the write strobe is high and the bus is released, for exactly ACC clocks starting at the accepting edge.
- R6: The inbound byte is registered at the last edge of the ACC-clock window. In the next clock output enable is high and the read-valid strobe is high for exactly one clock, carrying that byte. This is ACC clocks after the accepting edge.
- R7: The bus drive-enable is never high in a cycle where the memory is driving, which is when chip select is low, output enable is low and the write strobe is high.
- R8: Before the bus drive-enable rises there is at least one clock with output enable high and the bus released, including after a read that is directly followed by a write.
- R9: WP = ceil(T_WP_PS/CLK_PS) and ACC = ceil(T_ACC_PS/CLK_PS), each at least 1. With the defaults (5000, 7000, 12000) WP is 2 and ACC is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Controller idle, command can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | Read byte valid, one-clock strobe |
| rsp_rdata_o | output | 8 | Read byte |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_addr_o | output | 17 | Memory address bus |
| sram_dq_o | output | 8 | Outbound data byte |
| sram_dq_oe_o | output | 1 | Outbound data drive-enable |
| sram_dq_i | input | 8 | Inbound data byte |

## Verification
The bench counts clock edges and records the count at the edge that accepts each command. With that reference:
- a read response is due ACC edges later;
- ready is due back WP+2 edges after a write and ACC+1 edges after a read.

The bench's memory model returns a poison byte until output enable has been low for ACC sampled cycles. An early capture therefore shows up as a data mismatch. A late capture shows up as a timing mismatch.

All outputs are sampled on falling edges. The memory model takes write data on the rising edge of the write strobe, so a byte that is released too early is lost and a later read reports it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS,
    ST_R_DONE
  } seq_state_e;

  // ceil(t/clk), never below one clock
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_timer_parks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && done_o) |=> done_o);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // address and write byte frozen for the whole access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  p_rdata_only_on_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_o));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 2,
  parameter int unsigned WP_LOAD  = 1,
  parameter int unsigned ACC_LOAD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             rsp_valid_o,
  output logic             ce_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             dq_oe_o
);

  seq_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_IDLE) && req_valid_i;
  assign capture_o = (state_q == ST_R_ACCESS) && tmr_done_i;

  // read window is armed on accept, write pulse on setup
  assign tmr_load_o = (accept_o && !req_we_i) || (state_q == ST_W_SETUP);
  assign tmr_val_o  = (state_q == ST_W_SETUP) ? CNT_W'(WP_LOAD) : CNT_W'(ACC_LOAD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = req_we_i ? ST_W_SETUP : ST_R_ACCESS;
      ST_W_SETUP:  state_d = ST_W_PULSE;
      ST_W_PULSE:  if (tmr_done_i) state_d = ST_W_HOLD;
      ST_W_HOLD:   state_d = ST_IDLE;
      ST_R_ACCESS: if (tmr_done_i) state_d = ST_R_DONE;
      ST_R_DONE:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // pin flops fed from next state: glitch-free strobes, same-edge timing
  logic ce_q, we_q, oe_q, dqoe_q, ready_q, rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      ready_q <= 1'b1;
      rsp_q   <= 1'b0;
    end else begin
      ce_q    <= (state_d == ST_IDLE);
      we_q    <= (state_d != ST_W_PULSE);
      oe_q    <= (state_d != ST_R_ACCESS);
      dqoe_q  <= (state_d == ST_W_SETUP) || (state_d == ST_W_PULSE) || (state_d == ST_W_HOLD);
      ready_q <= (state_d == ST_IDLE);
      rsp_q   <= (state_d == ST_R_DONE);
    end
  end

  assign ce_no       = ce_q;
  assign we_no       = we_q;
  assign oe_no       = oe_q;
  assign dq_oe_o     = dqoe_q;
  assign ready_o     = ready_q;
  assign rsp_valid_o = rsp_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce_no && we_no && oe_no && !dq_oe_o && !rsp_valid_o));

  p_we_needs_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (!ce_no && oe_no && dq_oe_o));

  p_hold_after_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (dq_oe_o && !ce_no));

  p_read_bus_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (!ce_no && we_no && !ready_o));

  p_rsp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_no_contention_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe_o && !ce_no && !oe_no && we_no));

  p_turnaround_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> ($past(oe_no) && oe_no));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_WP_PS   = 7000,
  parameter int unsigned T_ACC_PS  = 12000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned WP_CYC  = ps_to_cycles(T_WP_PS, CLK_PS);
  localparam int unsigned ACC_CYC = ps_to_cycles(T_ACC_PS, CLK_PS);
  localparam int unsigned MAX_CYC = (WP_CYC > ACC_CYC) ? WP_CYC : ACC_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_seq_fsm #(
    .CNT_W    (CNT_W),
    .WP_LOAD  (WP_CYC - 1),
    .ACC_LOAD (ACC_CYC - 1)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept),
    .capture_o   (capture),
    .ready_o     (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .ce_no       (sram_ce_no),
    .we_no       (sram_we_no),
    .oe_no       (sram_oe_no),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .capture_i (capture),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .rdata_o   (rsp_rdata_o)
  );

  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o)));

  p_accept_drops_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && !sram_ce_no));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  localparam int unsigned CLK_PS = 5000;
  localparam int unsigned WP     = (7000 + CLK_PS - 1) / CLK_PS;   // 2
  localparam int unsigned ACC    = (12000 + CLK_PS - 1) / CLK_PS;  // 3

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rsp_valid, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o;
  logic [16:0] s_addr;
  logic [7:0]  dq_i = 8'hEE;

  always #2.5ns clk = ~clk;

  sram_async_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .sram_addr_o(s_addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // memory model
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  int oe_run = 0;

  always @(posedge we_n) begin
    if (rst_n && ce_n === 1'b0 && dq_oe === 1'b1) mem[int'(s_addr)] = dq_o;
  end

  always @(negedge clk) begin
    if (ce_n === 1'b0 && oe_n === 1'b0 && we_n === 1'b1) oe_run = oe_run + 1;
    else oe_run = 0;
    if (oe_run >= ACC) dq_i = mem.exists(int'(s_addr)) ? mem[int'(s_addr)] : 8'h00;
    else dq_i = 8'hEE;
  end

  // scoreboard
  typedef struct { logic [7:0] data; int due; } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid === 1'b1) begin
      if (q.size() == 0) chk(0, "R6 unexpected rsp", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rdata === e.data, "R6 read data", int'(rdata), int'(e.data));
        chk(cyc == e.due, "R6 rsp cycle", cyc, e.due);
      end
    end
  end

  // pin protocol monitor
  int we_low = 0;
  int oe_high = 0;
  bit prev_dqoe = 0;
  bit contention = 0;
  logic [16:0] la;
  logic [7:0]  ld;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && !ce_n && !oe_n && we_n) contention = 1;
      if (!oe_n) chk(!ce_n && we_n && !dq_oe, "R5 read strobes", {ce_n, we_n, dq_oe}, 3'b010);
      if (!we_n) begin
        if (we_low == 0) chk(!ce_n && oe_n, "R3 write strobes", {ce_n, oe_n}, 2'b01);
        else chk(s_addr === la && dq_o === ld, "R4 addr/data stable", int'(dq_o), int'(ld));
        la = s_addr; ld = dq_o;
        we_low++;
      end else if (we_low != 0) begin
        chk(we_low == WP, "R3/R9 write pulse width", we_low, WP);
        chk(dq_oe && !ce_n, "R4 hold after strobe", {dq_oe, ce_n}, 2'b10);
        we_low = 0;
      end
      if (dq_oe && !prev_dqoe) chk(oe_high >= 1 && oe_n, "R8 turnaround", oe_high, 1);
      prev_dqoe = dq_oe;
      if (oe_n && !dq_oe) oe_high++;
      else if (!oe_n) oe_high = 0;
    end
  end

  // driver: called at a falling edge
  task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    int n, busy;
    bit quiet;
    valid = 1'b1; we = w; addr = a; wdata = d;
    while (ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    valid = 1'b0; we = 1'b0; addr = 17'h15555; wdata = 8'h5A;
    n = cyc;
    if (w) ref_mem[int'(a)] = d;
    else begin
      exp_t e;
      e.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
      e.due = n + ACC;
      q.push_back(e);
    end
    busy = w ? WP + 2 : ACC + 1;
    quiet = 1;
    for (int i = 0; i < busy; i++) begin
      if (ready !== 1'b0) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R2 ready low during access", int'(quiet), 1);
    chk(ready === 1'b1 && ce_n === 1'b1 && dq_oe === 1'b0, "R1/R2 idle after access",
        {ready, ce_n, dq_oe}, 3'b110);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", cyc, 20000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe && ready && !rsp_valid, "R1 reset state",
        {ce_n, we_n, oe_n, dq_oe, ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1 && ce_n === 1'b1, "R1 idle after reset", {ready, ce_n}, 2'b11);

    issue(1, 17'h00000, 8'hA5);
    issue(1, 17'h1FFFF, 8'h3C);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h00123, 8'h00);            // never written
    issue(1, 17'h00123, 8'hFF);            // write right after read: R8
    issue(1, 17'h00123, 8'h01);            // overwrite
    issue(0, 17'h00123, 8'h00);
    for (int i = 0; i < 40; i++) begin
      logic [16:0] a;
      a = 17'($urandom_range(0, 15)) << (i % 13);
      issue(($urandom & 1) == 1, a, 8'($urandom));
    end
    for (int i = 0; i < 16; i++) issue(0, 17'(i), 8'h00);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6 all responses seen", q.size(), 0);
    chk(!contention, "R7 no bus contention", int'(contention), 0);
    finish_run();
  end

endmodule